// File: doc/BRIEF.md
# SD card SPI-mode response receiver

After a command frame has gone out on an SPI link to a memory card, this block collects the card's answer. It asks a neighbouring byte shifter for one exchange at a time, always sending all-ones, and skips the idle gap of all-ones bytes that comes before the answer. The first byte that is not all-ones is the status byte. The block then takes in the extra bytes that the selected response type carries. These are one more status byte for the two-byte type, or a 32-bit word sent most significant byte first for the five-byte type.

The status byte is sorted into an error class. For the busy-signalling type, the block keeps polling while the card answers with zero bytes. It stops at the first non-zero byte, or when a cycle counter set from the clock frequency and a time limit runs out. It then pulses `done` with a result code and the captured values. It also holds a chip-select request from the start of the response until any error result, so a failing exchange frees the card at once.

Top module: `sdr_resp_rx`

## Requirements
- R1: After reset, `done`, `cs_hold` and `byte_req` are low, and `result`, `resp_status` and `resp_word` are zero.
- R2: `byte_req` is high while the block waits for a byte of the response and low once `done` has been given. Every exchange it asks for sends `byte_tx` = 0xFF.
- R3: Up to GAP_MAX (default 8) bytes of 0xFF before the status byte are skipped. The first other byte is the status byte and appears in `resp_status[7:0]`.
- R4: If GAP_MAX+1 bytes of 0xFF arrive in a row while hunting, the block finishes with result 1 (gap timeout).
- R5: A status byte with bit 7 set ends the response at once with result 2 (malformed), and no extra byte is requested.
- R6: The status bits are sorted in priority order. Any of bit 6 (parameter), bit 5 (address) or bit 2 (illegal command) gives result 3. Otherwise bit 3 (command CRC) gives result 4. Otherwise bit 4 (erase sequence) or bit 1 (erase reset) gives result 5. Bit 0 (idle) alone, or a zero byte, gives result 0.
- R7: With `rsp_type` = 2, one more byte follows the status byte and is placed in `resp_status[15:8]`.
- R8: With `rsp_type` = 3, four more bytes follow. They are assembled first-received-most-significant into `resp_word`. `rsp_type` = 0 takes the status byte only.
- R9: With `rsp_type` = 1, the block keeps requesting bytes while they read 0x00 and finishes on the first non-zero byte. The result is the class of the status byte.
- R10: If the busy phase lasts (CLK_HZ/1000)·BUSY_MS cycles without a non-zero byte, the block finishes. The result is 6 (busy timeout) when the status class was 0; otherwise the status class is kept.
- R11: `done` is a one-cycle pulse, valid with `result`. `cs_hold` rises when a response starts. It is cleared together with `done` when the result is not zero and stays high when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin receiving a response (taken while idle) |
| rsp_type | input | 2 | 0 status only, 1 busy-signalling, 2 two-byte, 3 five-byte |
| byte_req | output | 1 | Request for a byte exchange |
| byte_tx | output | 8 | Byte to send during the exchange (all-ones) |
| byte_vld | input | 1 | One received byte is present this cycle |
| byte_rx | input | 8 | Received byte |
| done | output | 1 | Response finished, one-cycle pulse |
| result | output | 3 | Result code |
| resp_status | output | 16 | Status byte in [7:0], second status byte in [15:8] |
| resp_word | output | 32 | Four extra bytes, first received in [31:24] |
| cs_hold | output | 1 | Keep chip select asserted |

## Verification
A wrong hunt counter shows up as a `done` one byte early or late around the ninth all-ones byte. A wrong remaining-byte count either leaves `byte_req` high after the last expected byte, or produces a shifted `resp_word` or `resp_status[15:8]`. Both appear on the `done` cycle that follows the final byte.

A class latched at the wrong moment gives a wrong result code or a wrong `cs_hold` on that same cycle. A broken busy timer shows up only as a `done` that comes far from the configured cycle count after the status byte.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [1:0] {
    RT_R1  = 2'd0,
    RT_R1B = 2'd1,
    RT_R2  = 2'd2,
    RT_R3  = 2'd3
  } rsp_type_e;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_GAP_TO  = 3'd1,
    RES_BADRSP  = 3'd2,
    RES_ARG     = 3'd3,
    RES_CRC     = 3'd4,
    RES_IO      = 3'd5,
    RES_BUSY_TO = 3'd6
  } result_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_EXTRA = 2'd2,
    ST_BUSY  = 2'd3
  } rx_state_e;

  // number of bytes that follow the status byte
  function automatic logic [2:0] extra_len(rsp_type_e t);
    case (t)
      RT_R2:   extra_len = 3'd1;
      RT_R3:   extra_len = 3'd4;
      default: extra_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdr_r1_classify.sv
module sdr_r1_classify
  import sdr_pkg::*;
(
  input  logic [6:0] r1,
  output result_e    cls
);

  logic arg_err;
  logic crc_err;
  logic io_err;

  assign arg_err = r1[6] | r1[5] | r1[2];
  assign crc_err = r1[3];
  assign io_err  = r1[4] | r1[1];

  always_comb begin
    if (arg_err)      cls = RES_ARG;
    else if (crc_err) cls = RES_CRC;
    else if (io_err)  cls = RES_IO;
    else              cls = RES_OK;
  end

endmodule

// File: rtl/sdr_cycle_timer.sv
module sdr_cycle_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign expired = (cnt_q == LAST);
  assign cnt_en  = clr | (en & ~expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sdr_byte_shift.sv
module sdr_byte_shift #(
  parameter int unsigned NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic [7:0]            din,
  output logic [8*NBYTES-1:0]   q
);

  localparam int unsigned W = 8 * NBYTES;

  logic [W-1:0] q_d;
  logic         q_en;

  assign q_en = clr | en;

  always_comb begin
    if (clr) q_d = '0;
    else     q_d = {q[W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/sdr_resp_rx.sv
module sdr_resp_rx
  import sdr_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned BUSY_MS = 3000,
  parameter int unsigned GAP_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  rsp_type,
  output logic        byte_req,
  output logic [7:0]  byte_tx,
  input  logic        byte_vld,
  input  logic [7:0]  byte_rx,
  output logic        done,
  output logic [2:0]  result,
  output logic [15:0] resp_status,
  output logic [31:0] resp_word,
  output logic        cs_hold
);

  localparam int unsigned BUSY_CYC = (CLK_HZ / 1000) * BUSY_MS;
  localparam int unsigned GW       = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MAX);

  rx_state_e   state_q, state_d;
  rsp_type_e   type_q, type_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [2:0]  left_q, left_d;
  result_e     cls_q, cls_d;
  logic        done_q, done_d;
  result_e     res_q, res_d;
  logic [15:0] stat_q, stat_d;
  logic        cs_q, cs_d;

  result_e     cls_now;
  logic        busy_exp;
  logic        sh_clr, sh_en;
  logic        fin;
  result_e     fin_code;

  sdr_r1_classify u_cls (
    .r1  (byte_rx[6:0]),
    .cls (cls_now)
  );

  sdr_cycle_timer #(.LIMIT(BUSY_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_q != ST_BUSY),
    .en      (state_q == ST_BUSY),
    .expired (busy_exp)
  );

  sdr_byte_shift #(.NBYTES(4)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sh_clr),
    .en    (sh_en),
    .din   (byte_rx),
    .q     (resp_word)
  );

  assign byte_req    = (state_q != ST_IDLE);
  assign byte_tx     = 8'hFF;
  assign done        = done_q;
  assign result      = res_q;
  assign resp_status = stat_q;
  assign cs_hold     = cs_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    type_d   = type_q;
    gap_d    = gap_q;
    left_d   = left_q;
    cls_d    = cls_q;
    done_d   = 1'b0;
    res_d    = res_q;
    stat_d   = stat_q;
    cs_d     = cs_q;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    fin      = 1'b0;
    fin_code = RES_OK;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HUNT;
          type_d  = rsp_type_e'(rsp_type);
          gap_d   = '0;
          stat_d  = '0;
          cls_d   = RES_OK;
          cs_d    = 1'b1;
          sh_clr  = 1'b1;
        end
      end

      ST_HUNT: begin
        if (byte_vld) begin
          if (byte_rx == 8'hFF) begin
            if (gap_q == GAP_LAST) begin
              fin      = 1'b1;
              fin_code = RES_GAP_TO;
            end else begin
              gap_d = gap_q + 1'b1;
            end
          end else begin
            stat_d = {8'h00, byte_rx};
            if (byte_rx[7]) begin
              fin      = 1'b1;
              fin_code = RES_BADRSP;
            end else begin
              cls_d = cls_now;
              if (extra_len(type_q) != 3'd0) begin
                left_d  = extra_len(type_q);
                state_d = ST_EXTRA;
              end else if (type_q == RT_R1B) begin
                state_d = ST_BUSY;
              end else begin
                fin      = 1'b1;
                fin_code = cls_now;
              end
            end
          end
        end
      end

      ST_EXTRA: begin
        if (byte_vld) begin
          sh_en  = 1'b1;
          left_d = left_q - 1'b1;
          if (type_q == RT_R2) stat_d[15:8] = byte_rx;
          if (left_q == 3'd1) begin
            fin      = 1'b1;
            fin_code = cls_q;
          end
        end
      end

      ST_BUSY: begin
        if (byte_vld && (byte_rx != 8'h00)) begin
          fin      = 1'b1;
          fin_code = cls_q;
        end else if (busy_exp) begin
          fin      = 1'b1;
          fin_code = (cls_q == RES_OK) ? RES_BUSY_TO : cls_q;
        end
      end

      default: state_d = ST_IDLE;
    endcase

    if (fin) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      res_d   = fin_code;
      if (fin_code != RES_OK) cs_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      type_q  <= RT_R1;
      gap_q   <= '0;
      left_q  <= '0;
      cls_q   <= RES_OK;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      stat_q  <= '0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      gap_q   <= gap_d;
      left_q  <= left_d;
      cls_q   <= cls_d;
      done_q  <= done_d;
      res_q   <= res_d;
      stat_q  <= stat_d;
      cs_q    <= cs_d;
    end
  end

endmodule

// File: rtl/sdr_resp_rx_chk.sv
module sdr_resp_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [2:0]  result,
  input logic [15:0] resp_status,
  input logic        cs_hold,
  input logic        byte_req
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  cs_drop_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 3'd0) |-> !cs_hold);

  // R11
  cs_keep_on_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd0) |-> cs_hold);

  // R2
  req_idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_req);

  // R6
  ok_clean_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd0) |-> (resp_status[6:1] == 6'd0 && !resp_status[7]));

  // R6
  crc_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd4) |-> (resp_status[3] && !resp_status[6]
                                  && !resp_status[5] && !resp_status[2]));

  // R5
  bad_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd2) |-> resp_status[7]);

endmodule

bind sdr_resp_rx sdr_resp_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .result      (result),
  .resp_status (resp_status),
  .cs_hold     (cs_hold),
  .byte_req    (byte_req)
);

// File: tb/tb_sdr_resp_rx.sv
`timescale 1ns/1ps
module tb_sdr_resp_rx;

  localparam int unsigned TB_CLK_HZ  = 1_000_000;
  localparam int unsigned TB_BUSY_MS = 1;
  localparam int unsigned LIMIT      = (TB_CLK_HZ / 1000) * TB_BUSY_MS;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  rsp_type;
  logic        byte_req;
  logic [7:0]  byte_tx;
  logic        byte_vld;
  logic [7:0]  byte_rx;
  logic        done;
  logic [2:0]  result;
  logic [15:0] resp_status;
  logic [31:0] resp_word;
  logic        cs_hold;

  sdr_resp_rx #(.CLK_HZ(TB_CLK_HZ), .BUSY_MS(TB_BUSY_MS), .GAP_MAX(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rsp_type(rsp_type),
    .byte_req(byte_req), .byte_tx(byte_tx), .byte_vld(byte_vld),
    .byte_rx(byte_rx), .done(done), .result(result),
    .resp_status(resp_status), .resp_word(resp_word), .cs_hold(cs_hold)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       req;
    logic [2:0]  res;
    logic [15:0] stat;
    logic [31:0] word;
    bit          chk_word;
    bit          cs;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  feed_q[$];
  int          n_cmp  = 0;
  int          n_fail = 0;
  int          last_wait;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "result", {29'd0, result}, {29'd0, e.res});
        check(e.req, "resp_status", {16'd0, resp_status}, {16'd0, e.stat});
        if (e.chk_word) check(e.req, "resp_word", resp_word, e.word);
        check(e.req, "cs_hold", {31'd0, cs_hold}, {31'd0, e.cs});
      end
    end
  end

  task automatic run_case(string req, logic [1:0] t, logic [2:0] res,
                          logic [15:0] stat, logic [31:0] word, bit chk_word);
    exp_t e;
    bit   tx_seen;
    e.req = req; e.res = res; e.stat = stat; e.word = word;
    e.chk_word = chk_word; e.cs = (res == 3'd0);
    sb.push_back(e);
    @(negedge clk);
    rsp_type = t;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    tx_seen  = 1'b0;
    while (feed_q.size() > 0 && byte_req) begin
      if (!tx_seen) begin
        check("R2", "byte_tx", {24'd0, byte_tx}, 32'h0000_00FF);
        tx_seen = 1'b1;
      end
      byte_vld = 1'b1;
      byte_rx  = feed_q.pop_front();
      @(negedge clk);
    end
    byte_vld  = 1'b0;
    byte_rx   = 8'hFF;
    last_wait = 0;
    while (!done) begin
      @(negedge clk);
      last_wait++;
    end
    @(negedge clk);
    check("R2", "byte_req after done", {31'd0, byte_req}, 32'd0);
    check(req, "unused bytes", feed_q.size(), 0);
    feed_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rsp_type = 2'd0;
    byte_vld = 1'b0; byte_rx = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done", {31'd0, done}, 32'd0);
    check("R1", "cs_hold", {31'd0, cs_hold}, 32'd0);
    check("R1", "byte_req", {31'd0, byte_req}, 32'd0);
    check("R1", "result", {29'd0, result}, 32'd0);
    check("R1", "resp_status", {16'd0, resp_status}, 32'd0);
    check("R1", "resp_word", resp_word, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: one idle byte then clean status
    feed_q = '{8'hFF, 8'h00};
    run_case("R3", 2'd0, 3'd0, 16'h0000, 32'd0, 1'b0);
    // R6: idle bit alone is fine, status as first byte
    feed_q = '{8'h01};
    run_case("R6", 2'd0, 3'd0, 16'h0001, 32'd0, 1'b0);
    // R3: eight idle bytes is the longest accepted gap
    feed_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    run_case("R3", 2'd0, 3'd0, 16'h0000, 32'd0, 1'b0);
    // R4: nine idle bytes is a gap timeout
    feed_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_case("R4", 2'd0, 3'd1, 16'h0000, 32'd0, 1'b0);
    // R5: bit 7 set on a five-byte type ends at once
    feed_q = '{8'hFF, 8'h80};
    run_case("R5", 2'd3, 3'd2, 16'h0080, 32'd0, 1'b0);
    // R6: parameter and illegal command
    feed_q = '{8'hFF, 8'h44};
    run_case("R6", 2'd0, 3'd3, 16'h0044, 32'd0, 1'b0);
    // R6: address wins over CRC
    feed_q = '{8'h28};
    run_case("R6", 2'd0, 3'd3, 16'h0028, 32'd0, 1'b0);
    // R6: CRC wins over erase reset
    feed_q = '{8'hFF, 8'h0A};
    run_case("R6", 2'd0, 3'd4, 16'h000A, 32'd0, 1'b0);
    // R6: erase sequence and erase reset
    feed_q = '{8'h13};
    run_case("R6", 2'd0, 3'd5, 16'h0013, 32'd0, 1'b0);
    // R7: two-byte response
    feed_q = '{8'hFF, 8'hFF, 8'h00, 8'h5A};
    run_case("R7", 2'd2, 3'd0, 16'h5A00, 32'd0, 1'b0);
    // R8: five-byte response
    feed_q = '{8'hFF, 8'h01, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
    run_case("R8", 2'd3, 3'd0, 16'h0001, 32'hDEADBEEF, 1'b1);
    // R8: five-byte response with an error class kept
    feed_q = '{8'h09, 8'h12, 8'h34, 8'h56, 8'h78};
    run_case("R8", 2'd3, 3'd4, 16'h0009, 32'h12345678, 1'b1);
    // R9: busy bytes then release
    feed_q = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    run_case("R9", 2'd1, 3'd0, 16'h0000, 32'd0, 1'b0);
    // R9: error status with busy phase keeps its class
    feed_q = '{8'h04, 8'h00, 8'h01};
    run_case("R9", 2'd1, 3'd3, 16'h0004, 32'd0, 1'b0);
    // R10: busy never released
    feed_q = '{8'hFF, 8'h00};
    run_case("R10", 2'd1, 3'd6, 16'h0000, 32'd0, 1'b0);
    n_cmp++;
    if (last_wait < int'(LIMIT) - 2 || last_wait > int'(LIMIT) + 3) begin
      n_fail++;
      $display("FAIL R10 busy window: actual %0d expected about %0d", last_wait, LIMIT);
    end

    repeat (4) @(negedge clk);
    check("R11", "pending results", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule